// File: doc/BRIEF.md
# Masked-CRC wake-up frame matcher

This block watches a byte-wide receive stream and raises a wake-up pulse for each programmed pattern that a frame matches. A pattern is a 64-bit byte-select mask and a 32-bit expected CRC. While a frame arrives, each pattern lane runs an Ethernet CRC over the bytes its mask selects. Only the first 64 bytes of the frame count. When the last byte of the frame is accepted, the lane compares the complemented CRC with the expected value.

Software sets up the patterns through a small 16-bit register port. Each lane takes a copy of its configuration when a frame starts. A write that lands in the middle of a frame therefore cannot corrupt the comparison that is already under way.

Top module: `wake_pattern_matcher`

## Requirements
- R1: Register address = pattern*8 + slot. Slots 0..3 hold the mask, slot 4 holds CRC bits 15:0 and slot 5 holds CRC bits 31:16. Every slot can be written and read back. Read data is combinational while reg_rd is high and is zero while reg_rd is low. Slots 6 and 7 read as zero and ignore writes.
- R2: After reset, every mask and expected-CRC register reads zero.
- R3: Bit b of mask slot s selects frame byte 16*s+b+1, where byte 1 is the byte that carries rx_sof.
- R4: The CRC uses the reflected polynomial 0xEDB88320 on LSB-first data with a seed of 0xFFFFFFFF. It covers only the selected bytes. The complemented result must equal {slot5, slot4} for a match.
- R5: Bytes after the 64th byte of a frame have no effect on the result.
- R6: A frame that ends before its highest selected byte never matches.
- R7: match[p] is high for exactly one cycle. That cycle is the one that follows the clock edge that accepted the byte carrying rx_eof.
- R8: A pattern whose mask is all zero never matches, whatever its CRC registers hold.
- R9: A register write made while a frame is in progress affects matching only from the next rx_sof.
- R10: Cycles with rx_valid low are ignored. Bytes with rx_valid high that arrive outside a frame (after an end and before a start) are also ignored. An rx_sof in the middle of a frame restarts the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte on rx_data is valid |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | 4 | Register address (pattern*8 + slot) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |
| match | output | NUM_PAT | One-cycle match pulse per pattern |

## Verification
The assertions check four things on every cycle:
- a match pulse appears only on the cycle after an accepted end byte;
- a lane that has a zero mask stays silent;
- bytes that arrive outside a frame leave the position counter unchanged, and the counter never goes past the window;
- read data stays zero while no read is requested.

The CRC value itself, the order of the mask bits, how short frames are handled, and the point at which mid-frame writes take effect depend on frame contents. Only the bench's directed and random frames, checked against a bit-serial CRC model, can show these.

// File: rtl/wpm_pkg.sv
`timescale 1ns/1ps
package wpm_pkg;
  localparam int REG_W = 16;
  localparam int CRC_W = 32;
  localparam logic [31:0] CRC_SEED   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;

  // One byte of reflected Ethernet CRC, data consumed LSB first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/wpm_regs.sv
`timescale 1ns/1ps
module wpm_regs import wpm_pkg::*; #(
  parameter int NUM_PAT   = 2,
  parameter int WIN_BYTES = 64,
  parameter int SLOT_AW   = 3,
  parameter int AW        = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr,
  input  logic                                rd,
  input  logic [AW-1:0]                       addr,
  input  logic [REG_W-1:0]                    wdata,
  output logic [REG_W-1:0]                    rdata,
  output logic [NUM_PAT-1:0][WIN_BYTES-1:0]   mask_o,
  output logic [NUM_PAT-1:0][CRC_W-1:0]       crc_o
);
  localparam int MASK_SLOTS = WIN_BYTES / REG_W;
  localparam int PAT_W      = AW - SLOT_AW;

  logic [NUM_PAT-1:0][WIN_BYTES-1:0] mask_q;
  logic [NUM_PAT-1:0][CRC_W-1:0]     crc_q;
  logic [PAT_W-1:0]                  pat_sel;
  logic [SLOT_AW-1:0]                slot;

  assign pat_sel = addr[AW-1:SLOT_AW];
  assign slot    = addr[SLOT_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      crc_q  <= '0;
    end else if (wr) begin
      for (int p = 0; p < NUM_PAT; p++) begin
        if (PAT_W'(p) == pat_sel) begin
          if (int'(slot) < MASK_SLOTS)
            mask_q[p][int'(slot)*REG_W +: REG_W] <= wdata;
          else if (int'(slot) == MASK_SLOTS)
            crc_q[p][REG_W-1:0] <= wdata;
          else if (int'(slot) == MASK_SLOTS + 1)
            crc_q[p][CRC_W-1:REG_W] <= wdata;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      for (int p = 0; p < NUM_PAT; p++) begin
        if (PAT_W'(p) == pat_sel) begin
          if (int'(slot) < MASK_SLOTS)
            rdata = mask_q[p][int'(slot)*REG_W +: REG_W];
          else if (int'(slot) == MASK_SLOTS)
            rdata = crc_q[p][REG_W-1:0];
          else if (int'(slot) == MASK_SLOTS + 1)
            rdata = crc_q[p][CRC_W-1:REG_W];
        end
      end
    end
  end

  assign mask_o = mask_q;
  assign crc_o  = crc_q;
endmodule

// File: rtl/wpm_pos.sv
`timescale 1ns/1ps
module wpm_pos #(
  parameter int WIN_BYTES = 64,
  parameter int POS_W     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic             sof,
  input  logic             eof,
  output logic             accept,
  output logic             frame_end,
  output logic             in_frame,
  output logic [POS_W-1:0] pos_cnt,
  output logic [POS_W-1:0] byte_idx
);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(WIN_BYTES);

  logic [POS_W-1:0] pos_q;
  logic             in_frame_q;

  assign accept    = valid && (sof || in_frame_q);
  assign frame_end = accept && eof;
  assign byte_idx  = sof ? '0 : pos_q;
  assign in_frame  = in_frame_q;
  assign pos_cnt   = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q      <= '0;
      in_frame_q <= 1'b0;
    end else if (accept) begin
      in_frame_q <= !eof;
      if (sof)                 pos_q <= POS_W'(1);
      else if (pos_q != POS_MAX) pos_q <= pos_q + POS_W'(1);
    end
  end
endmodule

// File: rtl/wpm_lane.sv
`timescale 1ns/1ps
module wpm_lane import wpm_pkg::*; #(
  parameter int WIN_BYTES = 64,
  parameter int POS_W     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 sof,
  input  logic                 eof,
  input  logic [7:0]           data,
  input  logic [POS_W-1:0]     byte_idx,
  input  logic [WIN_BYTES-1:0] prog_mask,
  input  logic [CRC_W-1:0]     prog_crc,
  output logic                 match_o,
  output logic                 enabled_o
);
  localparam int IDX_W = $clog2(WIN_BYTES);

  // True when no selected byte lies beyond the last byte index seen.
  function automatic logic covered(input logic [WIN_BYTES-1:0] m, input logic [POS_W-1:0] last);
    for (int i = 0; i < WIN_BYTES; i++)
      if (m[i] && (i > int'(last))) return 1'b0;
    return 1'b1;
  endfunction

  logic [WIN_BYTES-1:0] act_mask_q, eff_mask;
  logic [CRC_W-1:0]     act_crc_q, eff_crc, crc_q, crc_base, crc_nxt;
  logic                 in_win, take, hit, match_q;

  assign eff_mask  = sof ? prog_mask : act_mask_q;
  assign eff_crc   = sof ? prog_crc  : act_crc_q;
  assign crc_base  = sof ? CRC_SEED  : crc_q;
  assign in_win    = byte_idx < POS_W'(WIN_BYTES);
  assign take      = in_win && eff_mask[byte_idx[IDX_W-1:0]];
  assign crc_nxt   = take ? crc_step(crc_base, data) : crc_base;
  assign enabled_o = |eff_mask;
  assign hit       = enabled_o && covered(eff_mask, byte_idx) && (~crc_nxt == eff_crc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mask_q <= '0;
      act_crc_q  <= '0;
      crc_q      <= CRC_SEED;
      match_q    <= 1'b0;
    end else begin
      match_q <= accept && eof && hit;
      if (accept) begin
        crc_q <= crc_nxt;
        if (sof) begin
          act_mask_q <= prog_mask;
          act_crc_q  <= prog_crc;
        end
      end
    end
  end

  assign match_o = match_q;
endmodule

// File: rtl/wake_pattern_matcher.sv
`timescale 1ns/1ps
module wake_pattern_matcher import wpm_pkg::*; #(
  parameter  int NUM_PAT   = 2,
  parameter  int WIN_BYTES = 64,
  localparam int SLOT_AW   = $clog2(WIN_BYTES / REG_W + 2),
  localparam int AW        = SLOT_AW + $clog2(NUM_PAT),
  localparam int POS_W     = $clog2(WIN_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic               rx_sof,
  input  logic               rx_eof,
  input  logic [7:0]         rx_data,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [NUM_PAT-1:0] match
);
  logic [NUM_PAT-1:0][WIN_BYTES-1:0] prog_mask;
  logic [NUM_PAT-1:0][CRC_W-1:0]     prog_crc;
  logic                              frame_accept, frame_end, in_frame;
  logic [POS_W-1:0]                  pos_cnt, byte_idx;
  logic [NUM_PAT-1:0]                lane_en;

  wpm_regs #(.NUM_PAT(NUM_PAT), .WIN_BYTES(WIN_BYTES), .SLOT_AW(SLOT_AW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .mask_o(prog_mask), .crc_o(prog_crc));

  wpm_pos #(.WIN_BYTES(WIN_BYTES), .POS_W(POS_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .valid(rx_valid), .sof(rx_sof), .eof(rx_eof),
    .accept(frame_accept), .frame_end(frame_end), .in_frame(in_frame),
    .pos_cnt(pos_cnt), .byte_idx(byte_idx));

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_lane
    wpm_lane #(.WIN_BYTES(WIN_BYTES), .POS_W(POS_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .accept(frame_accept), .sof(rx_sof), .eof(rx_eof),
      .data(rx_data), .byte_idx(byte_idx), .prog_mask(prog_mask[p]),
      .prog_crc(prog_crc[p]), .match_o(match[p]), .enabled_o(lane_en[p]));
  end
endmodule

// File: rtl/wpm_checker.sv
`timescale 1ns/1ps
module wpm_checker #(
  parameter int NUM_PAT   = 2,
  parameter int WIN_BYTES = 64,
  parameter int POS_W     = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_valid,
  input logic               rx_sof,
  input logic               reg_rd,
  input logic [15:0]        reg_rdata,
  input logic [NUM_PAT-1:0] match,
  input logic               frame_end,
  input logic               in_frame,
  input logic [POS_W-1:0]   pos_cnt,
  input logic [NUM_PAT-1:0] lane_en
);
  assert_match_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|match) |-> $past(frame_end));

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_off
    assert_zero_mask_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      match[p] |-> $past(lane_en[p]));
  end

  assert_stray_byte_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_sof && !in_frame) |=> $stable(pos_cnt));

  assert_window_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_cnt <= POS_W'(WIN_BYTES));

  assert_rdata_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0));
endmodule

bind wake_pattern_matcher wpm_checker #(.NUM_PAT(NUM_PAT), .WIN_BYTES(WIN_BYTES), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .match(match), .frame_end(frame_end), .in_frame(in_frame),
  .pos_cnt(pos_cnt), .lane_en(lane_en));

// File: tb/wake_pattern_matcher_test.sv
`timescale 1ns/1ps
module wake_pattern_matcher_test;
  localparam int NP = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, rx_valid, rx_sof, rx_eof, reg_wr, reg_rd;
  logic [7:0]  rx_data;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [NP-1:0] match;

  wake_pattern_matcher #(.NUM_PAT(NP), .WIN_BYTES(64)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match(match));

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0]  frm [0:127];
  logic [63:0] cfg_mask [NP];
  logic [31:0] cfg_crc  [NP];
  logic [63:0] snap_mask[NP];
  logic [31:0] snap_crc [NP];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-serial reference: one feedback per data bit, LSB first.
  function automatic logic [31:0] ref_crc(input logic [63:0] m, input int len);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic fb;
    for (int i = 0; i < len && i < 64; i++)
      if (m[i])
        for (int b = 0; b < 8; b++) begin
          fb = c[0] ^ frm[i][b];
          c  = c >> 1;
          if (fb) c = c ^ 32'hEDB8_8320;
        end
    return ~c;
  endfunction

  function automatic logic ref_hit(input int p, input int len);
    if (snap_mask[p] == 64'd0) return 1'b0;
    for (int i = len; i < 64; i++) if (snap_mask[p][i]) return 1'b0;
    return ref_crc(snap_mask[p], len) == snap_crc[p];
  endfunction

  function automatic void model_write(input logic [3:0] a, input logic [15:0] d);
    int p = int'(a[3]);
    int s = int'(a[2:0]);
    if (s < 4) cfg_mask[p][s*16 +: 16] = d;
    else if (s == 4) cfg_crc[p][15:0] = d;
    else if (s == 5) cfg_crc[p][31:16] = d;
  endfunction

  task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    model_write(a, d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic set_pat(input int p, input logic [63:0] m, input logic [31:0] c);
    for (int s = 0; s < 4; s++) reg_write(4'(p*8 + s), m[s*16 +: 16]);
    reg_write(4'(p*8 + 4), c[15:0]);
    reg_write(4'(p*8 + 5), c[31:16]);
  endtask

  // Sends frm[0..len-1]; optional gaps, optional write at byte wr_at, optional missing end.
  task automatic send_frame(input string req, input int len, input bit gaps, input int wr_at,
                            input logic [3:0] wa, input logic [15:0] wd, input bit no_end);
    logic [NP-1:0] exp;
    for (int p = 0; p < NP; p++) begin snap_mask[p] = cfg_mask[p]; snap_crc[p] = cfg_crc[p]; end
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        reg_wr = 1'b0; rx_valid = 1'b0; rx_data = 8'($urandom);
        rx_sof = 1'($urandom); rx_eof = 1'($urandom);
        @(posedge clk);
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1) && !no_end;
      rx_data = frm[i];
      reg_wr = (i == wr_at);
      if (i == wr_at) begin reg_addr = wa; reg_wdata = wd; model_write(wa, wd); end
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; reg_wr = 1'b0;
    if (!no_end) begin
      for (int p = 0; p < NP; p++) exp[p] = ref_hit(p, len);
      chk(req, 32'(match), 32'(exp));
    end
  endtask

  task automatic fill_frame(input int len);
    for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [63:0] m;
    process::self().srandom(32'd1234);
    rst_n = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_data = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    for (int p = 0; p < NP; p++) begin cfg_mask[p] = '0; cfg_crc[p] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2: everything reads zero after reset
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < 6; s++) begin
        reg_read(4'(p*8 + s), rd);
        chk("R2 reset value", 32'(rd), 32'd0);
      end

    // R1: write/read-back, unmapped slots, quiet read bus
    reg_write(4'hA, 16'h1234); reg_read(4'hA, rd); chk("R1 mask slot readback", 32'(rd), 32'h1234);
    reg_write(4'hD, 16'hBEEF); reg_read(4'hD, rd); chk("R1 crc high readback", 32'(rd), 32'hBEEF);
    reg_write(4'h6, 16'h5555); reg_read(4'h6, rd); chk("R1 unmapped slot 6", 32'(rd), 32'd0);
    reg_write(4'hF, 16'h7777); reg_read(4'hF, rd); chk("R1 unmapped slot 7", 32'(rd), 32'd0);
    @(negedge clk); #1 chk("R1 rdata with rd low", 32'(reg_rdata), 32'd0);
    reg_write(4'hA, 16'h0000); reg_write(4'hD, 16'h0000);

    // R3/R4/R7: bytes 1 and 18 selected on pattern 0; pattern 1 zero (R8)
    fill_frame(20);
    m = 64'd0; m[0] = 1'b1; m[17] = 1'b1;
    set_pat(0, m, ref_crc(m, 20));
    send_frame("R4 masked crc match", 20, 0, -1, '0, '0, 0);
    chk("R4 pattern0 hit", 32'(match[0]), 32'd1);
    chk("R8 zero mask silent", 32'(match[1]), 32'd0);
    @(negedge clk); chk("R7 pulse one cycle", 32'(match), 32'd0);

    // R3: mask bit 15 of slot 0 picks byte 16, a different byte
    reg_write(4'h0, 16'h8000); reg_write(4'h1, 16'h0000);
    send_frame("R3 bit order", 20, 0, -1, '0, '0, 0);
    m = 64'd0; m[15] = 1'b1;
    set_pat(0, m, ref_crc(m, 20));
    send_frame("R3 byte16 select", 20, 0, -1, '0, '0, 0);
    chk("R3 byte16 hit", 32'(match[0]), 32'd1);

    // R5: byte 64 selected, bytes beyond changed between frames
    fill_frame(100);
    m = 64'd0; m[63] = 1'b1;
    set_pat(0, m, ref_crc(m, 100));
    send_frame("R5 long frame", 100, 0, -1, '0, '0, 0);
    for (int i = 64; i < 100; i++) frm[i] = 8'($urandom);
    send_frame("R5 tail ignored", 100, 0, -1, '0, '0, 0);
    chk("R5 tail ignored hit", 32'(match[0]), 32'd1);

    // R6: bytes 5 and 40 selected; frame of 39 bytes with CRC of byte 5 only
    fill_frame(64);
    m = 64'd0; m[4] = 1'b1;
    set_pat(0, {24'd0, 1'b1, 34'd0, 1'b1, 4'd0}, ref_crc(m, 64));
    send_frame("R6 short frame", 39, 0, -1, '0, '0, 0);
    chk("R6 short no hit", 32'(match[0]), 32'd0);
    m[39] = 1'b1;
    set_pat(0, m, ref_crc(m, 40));
    send_frame("R6 exact length", 40, 0, -1, '0, '0, 0);
    chk("R6 exact hit", 32'(match[0]), 32'd1);

    // R9: mid-frame write of the CRC low half affects only the next frame
    fill_frame(30);
    m = 64'h0000_0000_0F00_00F1;
    set_pat(0, m, ref_crc(m, 30));
    send_frame("R9 old config used", 30, 0, 3, 4'h4, ~cfg_crc[0][15:0], 0);
    chk("R9 current frame hit", 32'(match[0]), 32'd1);
    send_frame("R9 new config used", 30, 0, -1, '0, '0, 0);
    chk("R9 next frame miss", 32'(match[0]), 32'd0);

    // R10: stray bytes, aborted frame, gaps, then a matching frame
    set_pat(0, m, ref_crc(m, 30));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 2); rx_data = 8'($urandom);
    end
    @(negedge clk); rx_valid = 1'b0; rx_eof = 1'b0;
    begin
      logic [7:0] keep [0:29];
      for (int i = 0; i < 30; i++) keep[i] = frm[i];
      fill_frame(12);
      send_frame("R10 aborted", 12, 1, -1, '0, '0, 1);
      for (int i = 0; i < 30; i++) frm[i] = keep[i];
    end
    send_frame("R10 restart with gaps", 30, 1, -1, '0, '0, 0);
    chk("R10 restart hit", 32'(match[0]), 32'd1);

    // Random frames against the model
    for (int n = 0; n < 60; n++) begin
      int len = 1 + int'($urandom % 90);
      int wat = -1;
      fill_frame(len);
      for (int p = 0; p < NP; p++) begin
        logic [63:0] rm = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
        if ($urandom % 10 == 0) rm = '0;
        set_pat(p, rm, ($urandom % 5 < 3) ? ref_crc(rm, len) : $urandom);
      end
      if (len > 1 && ($urandom % 2 == 0)) wat = 1 + int'($urandom % (len - 1));
      send_frame("R4 random frame", len, 1, wat, 4'($urandom), 16'($urandom), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule